// File: doc/BRIEF.md
# LCD panel power sequencer

This block brings an LCD panel's supplies and its display-enable line up and down in a fixed order. There are three outputs: a logic-supply control, a high-voltage-supply control and a display-on signal. A single level request asks for the panel to be on (1) or off (0). Every delay between two steps is measured in whole video frames, and a one-cycle frame-start strobe from the timing generator supplies the time base. A frame strobe counts only while a step is waiting for its delay.

A small register port holds four 4-bit delay fields and a logic-supply enable bit. Each field holds the wanted number of frames minus one. When the enable bit is 0, the logic-supply control is held low and its two steps are left out of both sequences. A two-bit status output reports off, powering on, on or powering off. A change in the request while a sequence is running is acted on only once the sequencer is fully on or fully off, so no step is ever cut short.

Top module: `lcd_pwr_seq`

## Requirements
- R1: After reset, both registers read 0, all three controls are low and the status is 00 (off).
- R2: Register 0 holds the four delay fields: bits 15:12 are high-voltage to display-on (power-up), bits 11:8 are display-on off to high-voltage off, bits 7:4 are logic to high-voltage (power-up) and bits 3:0 are high-voltage off to logic off. Register 1 bit 0 is the logic-supply enable. Bits 15:1 of register 1 always read 0. Reads are combinational.
- R3: With the enable set, a request of 1 in the off state raises the logic supply on the next clock. The high-voltage supply follows after the logic-to-high-voltage delay, and display-on follows after the high-voltage-to-display delay.
- R4: A delay with field value N ends on the clock edge of the (N+1)th frame strobe after its step began. Only strobes seen while that step is waiting are counted, so a value of 0 means one frame.
- R5: With the enable set, a request of 0 in the on state drops display-on on the next clock. The high-voltage supply drops after its delay, and then the logic supply drops after its own delay.
- R6: With the enable clear, the logic-supply control stays low. At power-up the high-voltage supply rises on the clock after the request. At power-down the sequence ends when the high-voltage supply drops.
- R7: A request change during powering on or powering off does not shorten or skip any step. It takes effect on the clock after the sequencer reaches the on or off state.
- R8: The status output is 00 when off, 01 while powering on, 10 when on and 11 while powering off.
- R9: Frame strobes in the off or on state, and a steady request, leave the outputs and the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| frame_stb_i | input | 1 | One-cycle frame-start strobe |
| pwr_on_i | input | 1 | Requested panel state (1 = on) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 1 | Register read address |
| rd_data_o | output | 16 | Register read data |
| lv_en_o | output | 1 | Logic-supply control |
| hv_en_o | output | 1 | High-voltage-supply control |
| disp_on_o | output | 1 | Display-on signal |
| status_o | output | 2 | Sequence status |

## Verification
The state register is the only register between a cause and its effect. A request seen in the off or on state, or a strobe that ends a delay, therefore changes the controls and the status one clock edge later. The bench drives every stimulus for exactly one rising edge and samples on the falling edge that follows, which is the cycle the result is due. Register reads are combinational and are checked a short settle time after the address changes. The bench sweeps delay values 0 to 2 in every field, with the enable both set and clear. For each strobe it checks that nothing moves before strobe N+1 and that the step fires exactly at strobe N+1.

// File: rtl/lcd_pwr_pkg.sv
package lcd_pwr_pkg;

    localparam int FIELD_W = 4;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 1;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_UP_LV,
        ST_UP_HV,
        ST_ON,
        ST_DN_DON,
        ST_DN_HV
    } seq_st_e;

    typedef enum logic [1:0] {
        STAT_OFF = 2'd0,
        STAT_UP  = 2'd1,
        STAT_ON  = 2'd2,
        STAT_DN  = 2'd3
    } stat_e;

    typedef struct packed {
        logic [FIELD_W-1:0] up_hv_don;
        logic [FIELD_W-1:0] dn_don_hv;
        logic [FIELD_W-1:0] up_lv_hv;
        logic [FIELD_W-1:0] dn_hv_lv;
    } delay_cfg_t;

    typedef struct packed {
        logic lv;
        logic hv;
        logic don;
    } rails_t;

    function automatic stat_e stat_of(seq_st_e s);
        case (s)
            ST_OFF:             return STAT_OFF;
            ST_UP_LV, ST_UP_HV: return STAT_UP;
            ST_ON:              return STAT_ON;
            default:            return STAT_DN;
        endcase
    endfunction

    function automatic rails_t rails_of(seq_st_e s, logic lv_allowed);
        rails_t r;
        r.lv  = lv_allowed && (s != ST_OFF);
        r.hv  = (s == ST_UP_HV) || (s == ST_ON) || (s == ST_DN_DON);
        r.don = (s == ST_ON);
        return r;
    endfunction

    function automatic logic is_wait(seq_st_e s);
        return (s == ST_UP_LV) || (s == ST_UP_HV) ||
               (s == ST_DN_DON) || (s == ST_DN_HV);
    endfunction

endpackage

// File: rtl/lcd_pwr_regs.sv
module lcd_pwr_regs
    import lcd_pwr_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output delay_cfg_t        cfg_o,
    output logic              lv_allow_o
);

    localparam logic [ADDR_W-1:0] A_DELAY = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(1);

    delay_cfg_t cfg_q;
    logic       lv_allow_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q      <= '0;
            lv_allow_q <= 1'b0;
        end else if (wr_en_i) begin
            if (wr_addr_i == A_DELAY) cfg_q      <= delay_cfg_t'(wr_data_i);
            if (wr_addr_i == A_CTRL)  lv_allow_q <= wr_data_i[0];
        end
    end

    always_comb begin
        if (rd_addr_i == A_DELAY) rd_data_o = DATA_W'(cfg_q);
        else                      rd_data_o = {{(DATA_W-1){1'b0}}, lv_allow_q};
    end

    assign cfg_o      = cfg_q;
    assign lv_allow_o = lv_allow_q;

endmodule

// File: rtl/lcd_pwr_frame_timer.sv
module lcd_pwr_frame_timer
    import lcd_pwr_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               clr_i,
    input  logic               frame_stb_i,
    input  logic [FIELD_W-1:0] limit_i,
    output logic               expire_o
);

    logic [FIELD_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i)   cnt_q <= '0;
        else if (frame_stb_i) cnt_q <= cnt_q + 1'b1;
    end

    assign expire_o = frame_stb_i && (cnt_q == limit_i);

endmodule

// File: rtl/lcd_pwr_fsm.sv
module lcd_pwr_fsm
    import lcd_pwr_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               pwr_on_i,
    input  logic               lv_allow_i,
    input  delay_cfg_t         cfg_i,
    input  logic               expire_i,
    output logic               tmr_clr_o,
    output logic [FIELD_W-1:0] limit_o,
    output seq_st_e            state_o
);

    seq_st_e st_q, st_d;
    logic    waiting;

    assign waiting = is_wait(st_q) && !expire_i;

    always_comb begin
        case (st_q)
            ST_UP_LV:  limit_o = cfg_i.up_lv_hv;
            ST_UP_HV:  limit_o = cfg_i.up_hv_don;
            ST_DN_DON: limit_o = cfg_i.dn_don_hv;
            default:   limit_o = cfg_i.dn_hv_lv;
        endcase
    end

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_OFF:    if (pwr_on_i) st_d = lv_allow_i ? ST_UP_LV : ST_UP_HV;
            ST_UP_LV:  if (expire_i) st_d = ST_UP_HV;
            ST_UP_HV:  if (expire_i) st_d = ST_ON;
            ST_ON:     if (!pwr_on_i) st_d = ST_DN_DON;
            ST_DN_DON: if (expire_i) st_d = lv_allow_i ? ST_DN_HV : ST_OFF;
            ST_DN_HV:  if (expire_i) st_d = ST_OFF;
            default:   st_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= ST_OFF;
        else       st_q <= st_d;
    end

    assign tmr_clr_o = !waiting;
    assign state_o   = st_q;

endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
    import lcd_pwr_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              frame_stb_i,
    input  logic              pwr_on_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              lv_en_o,
    output logic              hv_en_o,
    output logic              disp_on_o,
    output logic [1:0]        status_o
);

    delay_cfg_t         cfg;
    logic               lv_allow;
    logic               tmr_clr;
    logic               expire;
    logic [FIELD_W-1:0] limit;
    seq_st_e            state;
    rails_t             rails;

    lcd_pwr_regs regs_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o),
        .cfg_o      (cfg),
        .lv_allow_o (lv_allow)
    );

    lcd_pwr_frame_timer tmr_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .clr_i       (tmr_clr),
        .frame_stb_i (frame_stb_i),
        .limit_i     (limit),
        .expire_o    (expire)
    );

    lcd_pwr_fsm fsm_i (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .pwr_on_i   (pwr_on_i),
        .lv_allow_i (lv_allow),
        .cfg_i      (cfg),
        .expire_i   (expire),
        .tmr_clr_o  (tmr_clr),
        .limit_o    (limit),
        .state_o    (state)
    );

    assign rails     = rails_of(state, lv_allow);
    assign lv_en_o   = rails.lv;
    assign hv_en_o   = rails.hv;
    assign disp_on_o = rails.don;
    assign status_o  = stat_of(state);

endmodule

// File: rtl/lcd_pwr_seq_chk.sv
module lcd_pwr_seq_chk (
    input logic        clk_i,
    input logic        rst_i,
    input logic        frame_stb_i,
    input logic        pwr_on_i,
    input logic        rd_addr_i,
    input logic [15:0] rd_data_o,
    input logic        hv_en_o,
    input logic        disp_on_o,
    input logic [1:0]  status_o
);

    // R2
    ctrl_reserved_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_addr_i |-> (rd_data_o[15:1] == 15'd0));

    // R3
    don_needs_hv_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        disp_on_o |-> hv_en_o);

    // R4
    don_on_frame_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(disp_on_o) |-> $past(frame_stb_i));

    // R5
    hv_off_on_frame_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(hv_en_o) |-> $past(frame_stb_i));

    // R9
    stay_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_o == 2'd0 && !pwr_on_i) |=> (status_o == 2'd0));

    // R8
    on_status_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_o == 2'd2) |-> disp_on_o);

endmodule

bind lcd_pwr_seq lcd_pwr_seq_chk chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .frame_stb_i (frame_stb_i),
    .pwr_on_i    (pwr_on_i),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o),
    .hv_en_o     (hv_en_o),
    .disp_on_o   (disp_on_o),
    .status_o    (status_o)
);

// File: tb/lcd_pwr_seq_tb_top.sv
module lcd_pwr_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stb = 1'b0;
    logic        pwr = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_addr = 1'b0;
    logic [15:0] rd_data;
    logic        lv, hv, don;
    logic [1:0]  stat;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    lcd_pwr_seq dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .frame_stb_i (stb),
        .pwr_on_i    (pwr),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data),
        .lv_en_o     (lv),
        .hv_en_o     (hv),
        .disp_on_o   (don),
        .status_o    (stat)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic outs(input string req, input logic e_lv, input logic e_hv,
                        input logic e_don, input logic [1:0] e_st);
        check(req, {12'd0, lv, hv, don, 1'b0}, {12'd0, e_lv, e_hv, e_don, 1'b0});
        check(req, {14'd0, stat}, {14'd0, e_st});
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic a, input logic [15:0] exp);
        rd_addr = a; #1;
        check(req, rd_data, exp);
    endtask

    task automatic pulse();
        stb = 1'b1;
        @(posedge clk); @(negedge clk);
        stb = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic run_cfg(input int a, input int b, input int c, input int d, input logic en);
        logic [15:0] v;
        v = {4'(b), 4'(c), 4'(a), 4'(d)};
        wr(1'b0, v);
        wr(1'b1, {15'd0, en});
        rd("R2", 1'b0, v);
        // R9: strobe while off changes nothing
        pulse();
        outs("R9", 1'b0, 1'b0, 1'b0, 2'd0);
        pwr = 1'b1;
        tick();
        if (en) begin
            outs("R3", 1'b1, 1'b0, 1'b0, 2'd1);
            for (int i = 0; i <= a; i++) begin
                pulse();
                outs("R4", 1'b1, i == a, 1'b0, 2'd1);
            end
        end else begin
            outs("R6", 1'b0, 1'b1, 1'b0, 2'd1);
        end
        for (int i = 0; i <= b; i++) begin
            pulse();
            outs("R3", en, 1'b1, i == b, (i == b) ? 2'd2 : 2'd1);
        end
        // R9: strobe while on changes nothing
        pulse();
        outs("R9", en, 1'b1, 1'b1, 2'd2);
        pwr = 1'b0;
        tick();
        outs("R5", en, 1'b1, 1'b0, 2'd3);
        for (int i = 0; i <= c; i++) begin
            pulse();
            if (en) outs("R5", 1'b1, i != c, 1'b0, 2'd3);
            else    outs("R6", 1'b0, i != c, 1'b0, (i == c) ? 2'd0 : 2'd3);
        end
        if (en) begin
            for (int i = 0; i <= d; i++) begin
                pulse();
                outs("R5", i != d, 1'b0, 1'b0, (i == d) ? 2'd0 : 2'd3);
            end
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        outs("R1", 1'b0, 1'b0, 1'b0, 2'd0);
        rd("R1", 1'b0, 16'h0000);
        rd("R1", 1'b1, 16'h0000);
        wr(1'b1, 16'hFFFF);
        rd("R2", 1'b1, 16'h0001);
        wr(1'b0, 16'hA5C3);
        rd("R2", 1'b0, 16'hA5C3);

        for (int e = 0; e < 2; e++)
            for (int a = 0; a < 3; a++)
                for (int b = 0; b < 3; b++)
                    for (int c = 0; c < 3; c++)
                        for (int d = 0; d < 3; d++)
                            run_cfg(a, b, c, d, e[0]);

        // R7: drop request mid power-up, sequence still completes
        wr(1'b0, 16'h1111);
        wr(1'b1, 16'h0001);
        pwr = 1'b1;
        tick();
        pulse();
        pwr = 1'b0;
        outs("R7", 1'b1, 1'b0, 1'b0, 2'd1);
        pulse();
        outs("R7", 1'b1, 1'b1, 1'b0, 2'd1);
        pulse();
        outs("R7", 1'b1, 1'b1, 1'b0, 2'd1);
        pulse();
        outs("R7", 1'b1, 1'b1, 1'b1, 2'd2);
        tick();
        outs("R7", 1'b1, 1'b1, 1'b0, 2'd3);
        // R7: raise request mid power-down, sequence still completes
        pulse();
        pwr = 1'b1;
        pulse();
        outs("R7", 1'b1, 1'b0, 1'b0, 2'd3);
        pulse();
        pulse();
        outs("R7", 1'b0, 1'b0, 1'b0, 2'd0);
        tick();
        outs("R7", 1'b1, 1'b0, 1'b0, 2'd1);
        report();
    end

endmodule